// File: doc/BRIEF.md
# Linear Track Fitter with Chi-Square Hypothesis Selection

This block takes one road candidate per transfer: six signed coordinates, one per detector layer, and a six-bit mask that marks which of them hold a real hit. Layers 0 to 4 are fine-resolution layers. Layer 5 carries the coarse outer-tracker measurement. For each fit hypothesis the block evaluates a set of linear constraint equations. Each equation is a constant plus a weighted sum of the coordinates. The block squares each residual and adds the squares into a chi-square. The hypotheses are the fit that uses all six layers and the five fits that each leave out one fine layer.

Only hypotheses that the mask permits take part. The block keeps the one with the smallest chi-square and reports three values: that chi-square, the layer the hypothesis left out, and a pass flag that compares the chi-square with a cut supplied with the candidate. Each hypothesis has its own set of constant and weight coefficients. Software loads them beforehand through a simple write port. The result is held in an output register behind a valid/ready handshake, so one candidate can be accepted on every cycle while the consumer keeps up.

Top module: `linfit_chisq`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A write with coef_we high stores coef_data in the coefficient addressed by coef_hyp (0 to 5), coef_con (0 to N_CON-1) and coef_term (0 is the constant, t = 1 to 6 is the weight of layer t-1). A write with coef_hyp above 5 or coef_term equal to 7 changes no coefficient.
- R3: For hypothesis h and constraint c, the raw sum is s = (a0 << FRAC_W) + sum over the used layers l of a(l+1) times x_l. The residual is r = s shifted right arithmetically by FRAC_W, which rounds toward minus infinity. The chi-square is the sum over all constraints of r squared. A hypothesis that leaves out layer k gives x_k no contribution.
- R4: A chi-square larger than 2^CHI_W-1 is reported as 2^CHI_W-1. It never wraps.
- R5: The all-layer hypothesis is eligible only when all six mask bits are 1. The hypothesis that leaves out fine layer k (k = 0 to 4) is eligible when every mask bit other than bit k is 1. Layer 5 is never left out.
- R6: The reported hypothesis is the eligible one with the smallest chi-square. On a tie, the order all-layer, omit 0, omit 1, ..., omit 4 decides, and the earlier hypothesis wins.
- R7: out_omit is 7 for the all-layer hypothesis and k for the hypothesis that leaves out layer k.
- R8: out_pass is 1 exactly when an eligible hypothesis exists and out_chi is strictly less than the in_cut value presented with the candidate.
- R9: When no hypothesis is eligible, out_chi is 2^CHI_W-1, out_omit is 7 and out_pass is 0.
- R10: A candidate is accepted when in_valid and in_ready are both 1. Its result appears with out_valid on the next cycle. While out_valid is 1 and out_ready is 0, in_ready is 0 and the result holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_hyp | input | 3 | Hypothesis index of the write |
| coef_con | input | CON_AW | Constraint index of the write |
| coef_term | input | 3 | Term index of the write (0 = constant) |
| coef_data | input | COEF_W | Signed coefficient value |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate can be taken |
| in_coord | input | 6*COORD_W | Signed coordinates, layer l in bits l*COORD_W upward |
| in_mask | input | 6 | Hit validity per layer |
| in_cut | input | CHI_W | Chi-square cut for the pass flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_chi | output | CHI_W | Best chi-square |
| out_omit | output | 3 | Omitted layer, 7 for none |
| out_pass | output | 1 | Best chi-square is below the cut |

## Verification
The bench builds the block with four constraints, 16-bit coordinates and coefficients, eight fraction bits and a 32-bit chi-square. With four constraints the coefficient store is small enough to reload completely for each of several coefficient sets. All 64 mask values are swept against each set with different coordinate patterns. This covers every eligibility case, including the all-ineligible cases, and it produces ties and near-minimum competitions among the six hypotheses. Cuts placed exactly at the chi-square and one above it test the pass boundary. A set of extreme coefficients drives the 32-bit accumulator into saturation.

// File: rtl/lfit_pkg.sv
// Shared constants for the linear track fitter.
// Assumes six layers: five fine layers (0..4) that may be omitted and one
// coarse outer layer (5) that every hypothesis uses.
package lfit_pkg;
    localparam int N_LAYER = 6;
    localparam int N_TERM  = N_LAYER + 1;   // constant plus one weight per layer
    localparam int N_HYP   = N_LAYER;       // all-layer plus one per fine layer
    localparam logic [2:0] OMIT_NONE = 3'd7;
endpackage

// File: rtl/lfit_coef_store.sv
// Coefficient register file: one constant and six weights per constraint,
// one full set per hypothesis. Writes outside the valid index range are
// dropped. All entries read out in parallel.
module lfit_coef_store
    import lfit_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int N_CON  = 4,
    localparam int CON_AW = (N_CON > 1) ? $clog2(N_CON) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               wr_hyp,
    input  logic [CON_AW-1:0]        wr_con,
    input  logic [2:0]               wr_term,
    input  logic signed [COEF_W-1:0] wr_data,
    output logic signed [COEF_W-1:0] coef [N_HYP][N_CON][N_TERM]
);
    localparam logic [2:0] HYP_LIM  = 3'(N_HYP);
    localparam logic [2:0] TERM_LIM = 3'(N_TERM);

    logic con_ok;

    // Range check on the constraint index only when it is not a full power of two
    generate
        if (N_CON == (1 << CON_AW)) begin : g_con_full
            assign con_ok = 1'b1;
        end else begin : g_con_part
            localparam logic [CON_AW:0] CON_LIM = (CON_AW+1)'(N_CON);
            assign con_ok = ({1'b0, wr_con} < CON_LIM);
        end
    endgenerate

    // Clear on reset, otherwise store one in-range coefficient per write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int h = 0; h < N_HYP; h++)
                for (int c = 0; c < N_CON; c++)
                    for (int t = 0; t < N_TERM; t++)
                        coef[h][c][t] <= '0;
        end else if (wr_en && con_ok && (wr_hyp < HYP_LIM) && (wr_term < TERM_LIM)) begin
            coef[wr_hyp][wr_con][wr_term] <= wr_data;
        end
    end
endmodule

// File: rtl/lfit_hyp_eval.sv
// Chi-square of one fit hypothesis. Evaluates every constraint as a
// scaled constant plus weighted coordinates, drops FRAC_W fraction bits by
// an arithmetic shift, squares and accumulates, then saturates to CHI_W bits.
// DROP names the omitted layer; DROP = N_LAYER means all layers are used.
// Purely combinational.
module lfit_hyp_eval
    import lfit_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 8,
    parameter int CHI_W   = 32,
    parameter int N_CON   = 4,
    parameter int DROP    = N_LAYER
) (
    input  logic signed [COORD_W-1:0] coord [N_LAYER],
    input  logic signed [COEF_W-1:0]  coef  [N_CON][N_TERM],
    output logic [CHI_W-1:0]          chi
);
    localparam int SUM_W = COORD_W + COEF_W + 4;
    localparam int SQ_W  = 2 * SUM_W;
    localparam int ACC_W = SQ_W + $clog2(N_CON) + 1;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] res;
    logic signed [SQ_W-1:0]  sq;
    logic [ACC_W-1:0]        acc;

    // Residual, square and sum over all constraints, then clamp
    always_comb begin
        acc = '0;
        sum = '0;
        res = '0;
        sq  = '0;
        for (int c = 0; c < N_CON; c++) begin
            sum = SUM_W'(coef[c][0]);
            sum = sum <<< FRAC_W;
            for (int l = 0; l < N_LAYER; l++) begin
                if (l != DROP)
                    sum = sum + SUM_W'(coef[c][l+1]) * SUM_W'(coord[l]);
            end
            res = sum >>> FRAC_W;
            sq  = SQ_W'(res) * SQ_W'(res);
            acc = acc + ACC_W'($unsigned(sq));
        end
        chi = (|acc[ACC_W-1:CHI_W]) ? {CHI_W{1'b1}} : acc[CHI_W-1:0];
    end
endmodule

// File: rtl/lfit_best_select.sv
// Picks the eligible hypothesis with the smallest chi-square. A strict
// comparison in index order lets the earlier hypothesis win ties. With no
// eligible hypothesis it reports the maximum chi-square and omit code 7.
module lfit_best_select
    import lfit_pkg::*;
#(
    parameter int CHI_W = 32
) (
    input  logic [CHI_W-1:0] chi [N_HYP],
    input  logic [N_HYP-1:0] allow,
    output logic [CHI_W-1:0] best_chi,
    output logic [2:0]       best_omit,
    output logic             any
);
    // Linear scan for the minimum over eligible hypotheses
    always_comb begin
        best_chi  = {CHI_W{1'b1}};
        best_omit = OMIT_NONE;
        any       = 1'b0;
        for (int h = 0; h < N_HYP; h++) begin
            if (allow[h] && (!any || chi[h] < best_chi)) begin
                best_chi  = chi[h];
                best_omit = (h == 0) ? OMIT_NONE : 3'(h - 1);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/linfit_chisq.sv
// Linear track fitter top. Accepts one candidate (coordinates, hit mask,
// cut) per handshake and evaluates all six hypotheses in parallel. The
// winner is registered with a one-cycle latency. Assumes coefficients are
// loaded before candidates that depend on them are sent.
module linfit_chisq
    import lfit_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 8,
    parameter int CHI_W   = 32,
    parameter int N_CON   = 4,
    localparam int CON_AW = (N_CON > 1) ? $clog2(N_CON) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          coef_we,
    input  logic [2:0]                    coef_hyp,
    input  logic [CON_AW-1:0]             coef_con,
    input  logic [2:0]                    coef_term,
    input  logic signed [COEF_W-1:0]      coef_data,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [N_LAYER*COORD_W-1:0]    in_coord,
    input  logic [N_LAYER-1:0]            in_mask,
    input  logic [CHI_W-1:0]              in_cut,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [CHI_W-1:0]              out_chi,
    output logic [2:0]                    out_omit,
    output logic                          out_pass
);
    logic signed [COEF_W-1:0]  coef [N_HYP][N_CON][N_TERM];
    logic signed [COORD_W-1:0] coord [N_LAYER];
    logic [CHI_W-1:0]          hyp_chi [N_HYP];
    logic [N_HYP-1:0]          allow;
    logic [CHI_W-1:0]          best_chi;
    logic [2:0]                best_omit;
    logic                      any;
    logic [N_LAYER-1:0]        mask_q;
    logic [CHI_W-1:0]          cut_q;
    logic                      take;

    lfit_coef_store #(.COEF_W(COEF_W), .N_CON(N_CON)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_hyp(coef_hyp),
        .wr_con(coef_con), .wr_term(coef_term), .wr_data(coef_data), .coef(coef)
    );

    // Coordinate unpacking, eligibility and one evaluator per hypothesis
    assign allow[0] = &in_mask;
    generate
        for (genvar l = 0; l < N_LAYER; l++) begin : g_unpack
            assign coord[l] = in_coord[l*COORD_W +: COORD_W];
        end
        for (genvar k = 0; k < N_LAYER - 1; k++) begin : g_allow
            assign allow[k+1] = &(in_mask | N_LAYER'(1 << k));
        end
        for (genvar h = 0; h < N_HYP; h++) begin : g_hyp
            lfit_hyp_eval #(
                .COORD_W(COORD_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
                .CHI_W(CHI_W), .N_CON(N_CON),
                .DROP((h == 0) ? N_LAYER : h - 1)
            ) u_eval (
                .coord(coord), .coef(coef[h]), .chi(hyp_chi[h])
            );
        end
    endgenerate

    lfit_best_select #(.CHI_W(CHI_W)) u_sel (
        .chi(hyp_chi), .allow(allow), .best_chi(best_chi),
        .best_omit(best_omit), .any(any)
    );

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Output register: load on accept, clear once consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chi   <= '0;
            out_omit  <= OMIT_NONE;
            out_pass  <= 1'b0;
            mask_q    <= '0;
            cut_q     <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_chi   <= best_chi;
            out_omit  <= best_omit;
            out_pass  <= any && (best_chi < in_cut);
            mask_q    <= in_mask;
            cut_q     <= in_cut;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_chi) && $stable(out_omit) && $stable(out_pass));

    // R10
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R7
    omit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_omit == OMIT_NONE) || (out_omit < 3'(N_LAYER - 1)));

    // R5
    omit_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_omit != OMIT_NONE |-> &(mask_q | N_LAYER'(1 << out_omit)));

    // R9
    no_hypothesis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($countones(mask_q) < N_LAYER - 1) |-> out_omit == OMIT_NONE && !out_pass && (&out_chi));

    // R8
    pass_below_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pass |-> out_chi < cut_q);
endmodule

// File: tb/linfit_chisq_tb.sv
module linfit_chisq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16, KW = 16, FR = 8, XW = 32, NC = 4;
    localparam longint CHI_MAX = (64'd1 << XW) - 1;

    logic clk = 0, rst_n = 0;
    logic coef_we = 0;
    logic [2:0] coef_hyp = 0, coef_term = 0;
    logic [1:0] coef_con = 0;
    logic signed [KW-1:0] coef_data = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 1, out_pass;
    logic [6*CW-1:0] in_coord = 0;
    logic [5:0] in_mask = 0;
    logic [XW-1:0] in_cut = 0, out_chi;
    logic [2:0] out_omit;

    int total = 0, bad = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;
    longint cf [6][NC][7];
    longint crd [6];
    longint e_chi; int e_omit; bit e_pass;

    always #(CLK_PERIOD/2) clk = ~clk;

    linfit_chisq #(.COORD_W(CW), .COEF_W(KW), .FRAC_W(FR), .CHI_W(XW), .N_CON(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_hyp(coef_hyp),
        .coef_con(coef_con), .coef_term(coef_term), .coef_data(coef_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_coord(in_coord),
        .in_mask(in_mask), .in_cut(in_cut), .out_valid(out_valid),
        .out_ready(out_ready), .out_chi(out_chi), .out_omit(out_omit), .out_pass(out_pass)
    );

    function automatic int rnd(int span);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % span);
    endfunction

    function automatic longint hyp_chi(int h);
        longint acc = 0, s, r;
        int drop = (h == 0) ? 6 : h - 1;
        for (int c = 0; c < NC; c++) begin
            s = cf[h][c][0] * 256;
            for (int l = 0; l < 6; l++)
                if (l != drop) s += cf[h][c][l+1] * crd[l];
            r = s >>> FR;
            acc += r * r;
        end
        return (acc > CHI_MAX) ? CHI_MAX : acc;
    endfunction

    // Expected best result for a mask and cut (R3..R9)
    task automatic model(input logic [5:0] m, input logic [XW-1:0] cut);
        bit any = 0; longint c;
        e_chi = CHI_MAX; e_omit = 7;
        for (int h = 0; h < 6; h++) begin
            bit ok = (h == 0) ? (m == 6'h3f) : ((m | 6'(1 << (h-1))) == 6'h3f);
            if (ok) begin
                c = hyp_chi(h);
                if (!any || c < e_chi) begin
                    e_chi = c; e_omit = (h == 0) ? 7 : h - 1; any = 1;
                end
            end
        end
        e_pass = any && (e_chi < longint'(cut));
    endtask

    task automatic check(input bit ok, input string tag, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic wr(input int h, input int c, input int t, input longint v);
        @(negedge clk);
        coef_we = 1; coef_hyp = 3'(h); coef_con = 2'(c); coef_term = 3'(t); coef_data = 16'(v);
        @(negedge clk);
        coef_we = 0;
        if (h < 6 && t < 7) cf[h][c][t] = longint'($signed(16'(v)));
    endtask

    task automatic load_set(input int mode);
        for (int h = 0; h < 6; h++)
            for (int c = 0; c < NC; c++)
                for (int t = 0; t < 7; t++) begin
                    longint v;
                    if (mode == 0) v = rnd(511) - 255;
                    else if (mode == 1) v = (t == 0) ? c + 1 : 0;
                    else if (mode == 2) v = 32767;
                    else v = -32768;
                    wr(h, c, t, v);
                end
    endtask

    task automatic set_coords(input int mode);
        for (int l = 0; l < 6; l++) begin
            crd[l] = (mode == 0) ? longint'(rnd(4001) - 2000) : (mode == 1) ? 32767 : longint'(rnd(101) - 50);
            in_coord[l*CW +: CW] = CW'(crd[l]);
        end
    endtask

    // Send one candidate with a free consumer and compare one cycle later
    task automatic run_cand(input logic [5:0] m, input logic [XW-1:0] cut, input string tag);
        model(m, cut);
        @(negedge clk);
        in_valid = 1; in_mask = m; in_cut = cut; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check(out_valid === 1'b1 && out_chi === XW'(e_chi) && out_omit === 3'(e_omit) && out_pass === e_pass,
              tag, $sformatf("mask=%b got chi=%0d omit=%0d pass=%0b valid=%0b exp chi=%0d omit=%0d pass=%0b",
              m, out_chi, out_omit, out_pass, out_valid, e_chi, e_omit, e_pass));
    endtask

    task automatic sweep(input int cmode, input string tag);
        for (int m = 0; m < 64; m++) begin
            logic [XW-1:0] cut;
            model(6'(m), 0);
            cut = (m % 3 == 0) ? XW'(e_chi) : (m % 3 == 1) ? XW'(e_chi + 1) : XW'(rnd(1 << 30));
            if (m % 16 == 0) set_coords(cmode);
            run_cand(6'(m), cut, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1",
              $sformatf("out_valid=%0b in_ready=%0b exp 0/1", out_valid, in_ready));

        // R3 R5 R6 R7 R8 R9: random sets swept over every mask
        load_set(0);
        sweep(0, "R3 R5 R6 R7 R8 R9 random");
        sweep(2, "R3 R5 R6 R9 small coords");
        load_set(0);
        sweep(0, "R3 R5 R6 R8 second set");

        // R6: constant-only set gives equal chi for all hypotheses: earliest wins
        load_set(1);
        sweep(0, "R6 tie order");

        // R2: out-of-range writes ignored, in-range write takes effect
        load_set(0);
        set_coords(0);
        run_cand(6'h3f, 32'hffff_ffff, "R2 baseline");
        wr(6, 0, 1, 12345);
        wr(7, 1, 0, -999);
        wr(0, 2, 7, 32000);
        run_cand(6'h3f, 32'hffff_ffff, "R2 ignored writes");
        wr(0, 3, 2, 30000);
        run_cand(6'h3f, 32'hffff_ffff, "R2 applied write");
        run_cand(6'h3e, 32'hffff_ffff, "R2 omit0 hyp");

        // R4: saturation with large positive and negative coefficients
        load_set(2);
        set_coords(1);
        run_cand(6'h3f, 32'hffff_ffff, "R4 sat positive");
        check(out_chi === 32'hffff_ffff && out_pass === 1'b0, "R4",
              $sformatf("chi=%0h pass=%0b exp ffffffff/0", out_chi, out_pass));
        load_set(3);
        run_cand(6'h3f, 32'hffff_ffff, "R4 sat negative");
        run_cand(6'h3b, 32'hffff_ffff, "R4 sat omit2");

        // R10: stalled consumer holds result, blocks input, then drains
        load_set(0);
        set_coords(0);
        model(6'h3f, 32'hffff_ffff);
        @(negedge clk);
        in_valid = 1; in_mask = 6'h3f; in_cut = 32'hffff_ffff; out_ready = 0;
        @(negedge clk);
        in_mask = 6'h3d;
        check(out_valid === 1'b1 && in_ready === 1'b0 && out_chi === XW'(e_chi), "R10",
              $sformatf("stall valid=%0b ready=%0b chi=%0d exp 1/0/%0d", out_valid, in_ready, out_chi, e_chi));
        repeat (3) @(negedge clk);
        check(out_valid === 1'b1 && out_chi === XW'(e_chi) && out_omit === 3'(e_omit), "R10",
              $sformatf("hold chi=%0d omit=%0d exp %0d/%0d", out_chi, out_omit, e_chi, e_omit));
        model(6'h3d, 32'hffff_ffff);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check(out_valid === 1'b1 && out_chi === XW'(e_chi) && out_omit === 3'(e_omit), "R10",
              $sformatf("second chi=%0d omit=%0d exp %0d/%0d", out_chi, out_omit, e_chi, e_omit));
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R10",
              $sformatf("drain valid=%0b ready=%0b exp 0/1", out_valid, in_ready));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule